// File: doc/BRIEF.md
# Serial Audio Transmitter with Programmable Bit Clock

This block takes parallel audio words from a small transmit FIFO and shifts them out as a two-channel serial audio stream made of a bit clock, a word-select line and a data line. Each frame is 64 bit clocks long, split into a left slot and a right slot of 32 bit clocks each. Within a slot the sample goes out MSB first and the remaining bit periods are filled with zeros. The sample width is chosen by a small code. Framing is either standard I2S, where the MSB trails the word-select edge by one bit, or MSB-justified, where the MSB lines up with the edge.

The bit clock can be made locally by dividing the system clock, or it can come from outside. The same choice is made, independently, for the frame clock (word-select). A mono mode sends every FIFO word in both slots of a frame. The block raises a refill request while the FIFO level is at or below a programmable threshold. A flush input empties the FIFO. If the FIFO runs dry when a new word is needed, the previous word is sent again and a sticky underrun flag is set.

Software or a DMA engine writes words into the FIFO through `wr_en`/`wr_data`. The refill request signals that another burst can be written.

Top module: `i2s_tx`

## Requirements
- R1: While `enable` is low, `bclk_o`, `ws_o` and `sd_o` are held low and the divider and bit position are cleared. After `enable` rises, the first falling bit-clock edge starts left slot bit 0.
- R2: With `cfg_bclk_master`=1 the bit clock on `bclk_o` has a period of 2*(`cfg_div`+1) system clocks. `ws_o` and `sd_o` change only on its falling edge.
- R3: With `cfg_fclk_master`=1 a frame is 64 bit clocks. `ws_o` is low during the 32 bits of the left slot and high during the 32 bits of the right slot.
- R4: `cfg_width` selects the sample width: code 0 = 8 bits, 1 = 16, 3 = 20, 4 = 24. The sample is the low bits of the 24-bit word and is sent MSB first, with zeros in the rest of the slot. Any other code sends all-zero data.
- R5: With `cfg_msb_just`=0 the sample MSB is in slot bit 1 and slot bit 0 is zero. With `cfg_msb_just`=1 the MSB is in slot bit 0.
- R6: In stereo (`cfg_mono`=0) consecutive FIFO words fill the left slot and then the right slot. In mono (`cfg_mono`=1) each word fills both slots of one frame.
- R7: A role that is not master follows the outside clocks. With `cfg_bclk_master`=0 the bit advances on each falling edge of `ext_bclk`. With `cfg_fclk_master`=0 a slot starts when `ext_ws` changes, and `ext_ws`=0 means the left slot. `bclk_o` or `ws_o` stays low for a role that is not master.
- R8: `req_o` is high exactly when `enable` and `play_en` are high and `fifo_level` <= `cfg_req_thr`.
- R9: When a slot needs a new word and the FIFO is empty, the previous word is sent again and `underrun` becomes 1 and stays 1.
- R10: A `flush` cycle empties the FIFO (`fifo_level` becomes 0) and clears `underrun`. A write in the same cycle is dropped.
- R11: While `play_en` is low, `sd_o` stays low and no word is taken from the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (audio reference) clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Global enable of clocks and framing |
| play_en | input | 1 | Playback on: consume words, allow refill request |
| cfg_width | input | 3 | Sample width code |
| cfg_msb_just | input | 1 | 0 = standard I2S framing, 1 = MSB-justified |
| cfg_mono | input | 1 | Send each word on both channels |
| cfg_bclk_master | input | 1 | 1 = generate bit clock, 0 = use ext_bclk |
| cfg_fclk_master | input | 1 | 1 = generate word-select, 0 = use ext_ws |
| cfg_div | input | DIV_W | Bit-clock half period in system clocks, minus one |
| cfg_req_thr | input | LVL_W | Refill request threshold |
| flush | input | 1 | Empty FIFO and clear underrun |
| wr_en | input | 1 | FIFO write strobe |
| wr_data | input | 24 | Word to write (sample in low bits) |
| ext_bclk | input | 1 | External bit clock |
| ext_ws | input | 1 | External word-select |
| bclk_o | output | 1 | Generated bit clock |
| ws_o | output | 1 | Generated word-select |
| sd_o | output | 1 | Serial data |
| req_o | output | 1 | FIFO refill request |
| fifo_level | output | LVL_W | Words held in the FIFO |
| fifo_full | output | 1 | FIFO full; writes are dropped |
| underrun | output | 1 | Sticky underrun flag |

## Verification
The assertions check on every cycle that the lines stay quiet while the block is disabled, and that data and word-select move only on a falling edge of the generated bit clock. They also count the bit-clock falls between word-select changes to confirm the 32-bit slot. The FIFO is never read while empty, an underrun always raises the sticky flag, and a flush empties the FIFO. Only the directed scenarios can show the bit-exact slot contents for each width code and framing mode, mono duplication, the repeated word on underrun, the level-to-threshold request behaviour, and correct following of outside clocks. In each case the bench decodes the serial stream like a receiver would.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

  localparam int SAMPLE_W   = 24;
  localparam int CODE_W     = 3;
  localparam int SLOT_W     = 5;               // 32 bit clocks per slot
  localparam int POS_W      = SLOT_W + 1;      // channel bit on top
  localparam int SLOT_BITS  = 1 << SLOT_W;

  // Width in bits for a width code; 0 means unsupported (silence).
  function automatic int width_of(input logic [CODE_W-1:0] code);
    case (code)
      3'd0:    return 8;
      3'd1:    return 16;
      3'd3:    return 20;
      3'd4:    return 24;
      default: return 0;
    endcase
  endfunction

  // Serial bit for slot position spos of sample smp.
  function automatic logic slot_bit(input logic [SAMPLE_W-1:0] smp,
                                    input logic [CODE_W-1:0]   code,
                                    input logic                msbj,
                                    input logic [SLOT_W-1:0]   spos);
    int w;
    int idx;
    w   = width_of(code);
    idx = msbj ? int'(spos) : int'(spos) - 1;
    if (idx < 0 || idx >= w) return 1'b0;
    return smp[w - 1 - idx];
  endfunction

endpackage

// File: rtl/i2s_tx_fifo.sv
module i2s_tx_fifo #(
  parameter int W     = 24,
  parameter int DEPTH = 32,
  localparam int AW    = $clog2(DEPTH),
  localparam int LVL_W = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [W-1:0]     wr_data,
  input  logic             rd_en,
  output logic [W-1:0]     rd_data,
  output logic             empty,
  output logic             full,
  output logic [LVL_W-1:0] level
);

  logic [W-1:0]     mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [LVL_W-1:0] cnt;
  logic             do_wr, do_rd;

  assign empty   = (cnt == '0);
  assign full    = (cnt == LVL_W'(DEPTH));
  assign level   = cnt;
  assign rd_data = mem[rptr];
  assign do_wr   = wr_en && !full && !flush;
  assign do_rd   = rd_en && !empty && !flush;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else if (flush) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_wr) wptr <= wptr + 1'b1;
      if (do_rd) rptr <= rptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

endmodule

// File: rtl/i2s_tx_clkgen.sv
module i2s_tx_clkgen #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             bclk_master,
  input  logic [DIV_W-1:0] div,
  input  logic             ext_bclk,
  output logic             bclk_int,
  output logic             bit_tick
);

  logic [DIV_W-1:0] half_cnt;
  logic             bclk_q;
  logic [1:0]       ext_sync;
  logic             ext_prev;
  logic             half_done;
  logic             ext_fall;

  assign half_done = (half_cnt == div);
  assign ext_fall  = ext_prev && !ext_sync[1];

  // Outside clock is synchronised all the time so enabling gives no false edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_sync <= '0;
      ext_prev <= 1'b0;
    end else begin
      ext_sync <= {ext_sync[0], ext_bclk};
      ext_prev <= ext_sync[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_cnt <= '0;
      bclk_q   <= 1'b0;
    end else if (!enable || !bclk_master) begin
      half_cnt <= '0;
      bclk_q   <= 1'b0;
    end else if (half_done) begin
      half_cnt <= '0;
      bclk_q   <= ~bclk_q;
    end else begin
      half_cnt <= half_cnt + 1'b1;
    end
  end

  assign bclk_int = bclk_q;
  assign bit_tick = enable && (bclk_master ? (half_done && bclk_q) : ext_fall);

endmodule

// File: rtl/i2s_tx_framer.sv
module i2s_tx_framer
  import i2s_tx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                play_en,
  input  logic                fclk_master,
  input  logic                msb_just,
  input  logic                mono,
  input  logic [CODE_W-1:0]   width_code,
  input  logic                bit_tick,
  input  logic                ext_ws,
  input  logic                fifo_empty,
  input  logic [SAMPLE_W-1:0] fifo_head,
  output logic                pop,
  output logic                slot_start,
  output logic                underrun_evt,
  output logic                ws_o,
  output logic                sd_o
);

  logic [POS_W-1:0]    pos, nxt_pos;
  logic [1:0]          ws_sync;
  logic                ws_s;
  logic                ws_q, sd_q;
  logic [SAMPLE_W-1:0] hold;
  logic [SAMPLE_W-1:0] cur_smp;
  logic                need_word;

  assign ws_s = ws_sync[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ws_sync <= '0;
    else        ws_sync <= {ws_sync[0], ext_ws};
  end

  // Next bit position: free-running when frame master, resynchronised on
  // every word-select change otherwise.
  always_comb begin
    if (fclk_master)
      nxt_pos = pos + 1'b1;
    else if (ws_s != pos[POS_W-1])
      nxt_pos = {ws_s, {SLOT_W{1'b0}}};
    else
      nxt_pos = {pos[POS_W-1], pos[SLOT_W-1:0] + 1'b1};
  end

  assign slot_start   = bit_tick && (nxt_pos[SLOT_W-1:0] == '0);
  assign need_word    = slot_start && play_en && (!nxt_pos[POS_W-1] || !mono);
  assign pop          = need_word && !fifo_empty;
  assign underrun_evt = need_word && fifo_empty;
  assign cur_smp      = pop ? fifo_head : hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos  <= '1;
      ws_q <= 1'b0;
      sd_q <= 1'b0;
      hold <= '0;
    end else if (!enable) begin
      pos  <= '1;
      ws_q <= 1'b0;
      sd_q <= 1'b0;
      hold <= '0;
    end else if (bit_tick) begin
      pos  <= nxt_pos;
      ws_q <= fclk_master & nxt_pos[POS_W-1];
      sd_q <= play_en & slot_bit(cur_smp, width_code, msb_just, nxt_pos[SLOT_W-1:0]);
      if (pop) hold <= fifo_head;
    end
  end

  assign ws_o = ws_q;
  assign sd_o = sd_q;

endmodule

// File: rtl/i2s_tx.sv
module i2s_tx
  import i2s_tx_pkg::*;
#(
  parameter int DIV_W      = 4,
  parameter int FIFO_DEPTH = 32,
  localparam int LVL_W     = $clog2(FIFO_DEPTH) + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                play_en,
  input  logic [CODE_W-1:0]   cfg_width,
  input  logic                cfg_msb_just,
  input  logic                cfg_mono,
  input  logic                cfg_bclk_master,
  input  logic                cfg_fclk_master,
  input  logic [DIV_W-1:0]    cfg_div,
  input  logic [LVL_W-1:0]    cfg_req_thr,
  input  logic                flush,
  input  logic                wr_en,
  input  logic [SAMPLE_W-1:0] wr_data,
  input  logic                ext_bclk,
  input  logic                ext_ws,
  output logic                bclk_o,
  output logic                ws_o,
  output logic                sd_o,
  output logic                req_o,
  output logic [LVL_W-1:0]    fifo_level,
  output logic                fifo_full,
  output logic                underrun
);

  logic                bit_tick;
  logic                pop;
  logic                slot_start;
  logic                underrun_evt;
  logic                fifo_empty;
  logic [SAMPLE_W-1:0] fifo_head;
  logic                underrun_q;

  i2s_tx_fifo #(.W(SAMPLE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_en   (pop),
    .rd_data (fifo_head),
    .empty   (fifo_empty),
    .full    (fifo_full),
    .level   (fifo_level)
  );

  i2s_tx_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .bclk_master (cfg_bclk_master),
    .div         (cfg_div),
    .ext_bclk    (ext_bclk),
    .bclk_int    (bclk_o),
    .bit_tick    (bit_tick)
  );

  i2s_tx_framer u_framer (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .play_en      (play_en),
    .fclk_master  (cfg_fclk_master),
    .msb_just     (cfg_msb_just),
    .mono         (cfg_mono),
    .width_code   (cfg_width),
    .bit_tick     (bit_tick),
    .ext_ws       (ext_ws),
    .fifo_empty   (fifo_empty),
    .fifo_head    (fifo_head),
    .pop          (pop),
    .slot_start   (slot_start),
    .underrun_evt (underrun_evt),
    .ws_o         (ws_o),
    .sd_o         (sd_o)
  );

  // Sticky underrun; flush wins over a new event.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            underrun_q <= 1'b0;
    else if (flush)        underrun_q <= 1'b0;
    else if (underrun_evt) underrun_q <= 1'b1;
  end

  assign underrun = underrun_q;
  assign req_o    = enable && play_en && (fifo_level <= cfg_req_thr);

endmodule

// File: rtl/i2s_tx_chk.sv
module i2s_tx_chk #(
  parameter int LVL_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             cfg_bclk_master,
  input logic             cfg_fclk_master,
  input logic             flush,
  input logic             bclk_o,
  input logic             ws_o,
  input logic             sd_o,
  input logic [LVL_W-1:0] fifo_level,
  input logic             underrun,
  input logic             pop,
  input logic             underrun_evt
);

  logic       bclk_prev, ws_prev, seen_edge;
  logic [6:0] fall_cnt;
  logic       fall_w, ws_chg_w;

  assign fall_w   = bclk_prev && !bclk_o;
  assign ws_chg_w = (ws_prev != ws_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_prev <= 1'b0;
      ws_prev   <= 1'b0;
      seen_edge <= 1'b0;
      fall_cnt  <= '0;
    end else begin
      bclk_prev <= bclk_o;
      ws_prev   <= ws_o;
      if (!enable || !cfg_bclk_master || !cfg_fclk_master) begin
        seen_edge <= 1'b0;
        fall_cnt  <= '0;
      end else if (ws_chg_w) begin
        seen_edge <= 1'b1;
        fall_cnt  <= '0;
      end else if (fall_w) begin
        fall_cnt  <= fall_cnt + 1'b1;
      end
    end
  end

  // R1
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!bclk_o && !ws_o && !sd_o));

  // R2
  change_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(enable) && $past(cfg_bclk_master) && !fall_w) |-> ($stable(sd_o) && $stable(ws_o)));

  // R3
  slot_length_chk: assert property (@(posedge clk) disable iff (!rst_n || !enable)
    (ws_chg_w && seen_edge) |-> (fall_cnt == 7'd31));

  // R9
  underrun_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun_evt && !flush) |=> underrun);

  // R9
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !flush) |=> underrun);

  // R10
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (fifo_level == '0 && !underrun));

  // R9
  no_empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (fifo_level != '0));

endmodule

bind i2s_tx i2s_tx_chk #(.LVL_W(LVL_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .enable          (enable),
  .cfg_bclk_master (cfg_bclk_master),
  .cfg_fclk_master (cfg_fclk_master),
  .flush           (flush),
  .bclk_o          (bclk_o),
  .ws_o            (ws_o),
  .sd_o            (sd_o),
  .fifo_level      (fifo_level),
  .underrun        (underrun),
  .pop             (pop),
  .underrun_evt    (underrun_evt)
);

// File: tb/i2s_tx_tb.sv
`timescale 1ns/1ps
module i2s_tx_tb;

  localparam int LVL_W = 6;
  localparam int H     = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0, play_en = 1'b0;
  logic [2:0]  cfg_width = 3'd1;
  logic        cfg_msb_just = 1'b0, cfg_mono = 1'b0;
  logic        cfg_bclk_master = 1'b1, cfg_fclk_master = 1'b1;
  logic [3:0]  cfg_div = 4'd1;
  logic [LVL_W-1:0] cfg_req_thr = 6'd8;
  logic        flush = 1'b0, wr_en = 1'b0;
  logic [23:0] wr_data = '0;
  logic        ext_bclk = 1'b0, ext_ws = 1'b0;
  logic        bclk_o, ws_o, sd_o, req_o, fifo_full, underrun;
  logic [LVL_W-1:0] fifo_level;

  always #10 clk = ~clk;

  i2s_tx u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .play_en(play_en),
    .cfg_width(cfg_width), .cfg_msb_just(cfg_msb_just), .cfg_mono(cfg_mono),
    .cfg_bclk_master(cfg_bclk_master), .cfg_fclk_master(cfg_fclk_master),
    .cfg_div(cfg_div), .cfg_req_thr(cfg_req_thr), .flush(flush),
    .wr_en(wr_en), .wr_data(wr_data), .ext_bclk(ext_bclk), .ext_ws(ext_ws),
    .bclk_o(bclk_o), .ws_o(ws_o), .sd_o(sd_o), .req_o(req_o),
    .fifo_level(fifo_level), .fifo_full(fifo_full), .underrun(underrun)
  );

  int checks = 0;
  int errors = 0;
  int cyc_total = 0;
  bit done = 0;
  logic [23:0] words [16];
  int npush = 0;
  logic sdb [256];
  logic wsb [256];
  int got_bits = 0;
  int meas_per = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > 150000 && !done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc_total);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // Reference slot contents, bit p = slot position p.
  function automatic logic [31:0] exp_slot(input logic [23:0] word,
                                           input logic [2:0] code,
                                           input logic msbj);
    int w;
    logic [63:0] just;
    logic [31:0] r;
    case (code)
      3'd0: w = 8;
      3'd1: w = 16;
      3'd3: w = 20;
      3'd4: w = 24;
      default: w = 0;
    endcase
    just = '0;
    if (w > 0) just = (({40'd0, word}) & ((64'd1 << w) - 64'd1)) << (32 - w);
    for (int p = 0; p < 32; p++)
      r[p] = msbj ? just[31-p] : ((p == 0) ? 1'b0 : just[32-p]);
    return r;
  endfunction

  function automatic logic [23:0] word_at(input int idx);
    if (npush == 0) return '0;
    return (idx < npush) ? words[idx] : words[npush-1];
  endfunction

  task automatic idle_flush();
    @(negedge clk);
    enable = 0; play_en = 0; flush = 1;
    @(negedge clk);
    flush = 0;
    npush = 0;
  endtask

  task automatic push(input logic [23:0] w);
    @(negedge clk);
    wr_en = 1; wr_data = w;
    words[npush] = w;
    npush++;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic push_n(input int n);
    for (int i = 0; i < n; i++)
      push(24'(32'h9A5C3 * (i + 1) + 32'h800001 + i * 32'h10F0F));
  endtask

  task automatic cap_int(input int nbits);
    int guard = 0;
    int cyc = 0;
    int last_rise = -1;
    logic prev;
    logic seen_fall = 0;
    prev = bclk_o;
    got_bits = 0;
    while (got_bits < nbits && guard < 20000) begin
      @(negedge clk);
      guard++; cyc++;
      if (prev && !bclk_o) seen_fall = 1;
      if (!prev && bclk_o && seen_fall) begin
        sdb[got_bits] = sd_o;
        wsb[got_bits] = ws_o;
        if (last_rise >= 0) meas_per = cyc - last_rise;
        last_rise = cyc;
        got_bits++;
      end
      prev = bclk_o;
    end
  endtask

  task automatic check_frames(input int nframes, input logic [2:0] code,
                              input logic msbj, input logic mono,
                              input bit chk_ws, input string tag);
    for (int f = 0; f < nframes; f++) begin
      logic [31:0] wsv;
      for (int s = 0; s < 2; s++) begin
        logic [31:0] gotv, expv;
        int idx;
        idx  = mono ? f : 2 * f + s;
        expv = exp_slot(word_at(idx), code, msbj);
        for (int p = 0; p < 32; p++) gotv[p] = sdb[f*64 + s*32 + p];
        chk(gotv == expv, tag, $sformatf("frame %0d slot %0d data", f, s), gotv, expv);
      end
      if (chk_ws) begin
        for (int p = 0; p < 32; p++) wsv[p] = (wsb[f*64+p] == 1'b0) && (wsb[f*64+32+p] == 1'b1);
        chk(wsv == 32'hFFFF_FFFF, "R3", $sformatf("frame %0d word-select pattern", f), wsv, 32'hFFFF_FFFF);
      end
    end
  endtask

  task automatic run_int(input string tag, input logic [2:0] code, input logic msbj,
                         input logic mono, input logic [3:0] div,
                         input int nframes, input int nwords);
    idle_flush();
    cfg_width = code; cfg_msb_just = msbj; cfg_mono = mono; cfg_div = div;
    cfg_bclk_master = 1; cfg_fclk_master = 1;
    push_n(nwords);
    @(negedge clk);
    enable = 1; play_en = 1;
    cap_int(nframes * 64);
    enable = 0; play_en = 0;
    chk(got_bits == nframes * 64, tag, "bits captured", got_bits, nframes * 64);
    check_frames(nframes, code, msbj, mono, 1'b1, tag);
    chk(meas_per == 2 * (int'(div) + 1), "R2", "bit clock period", meas_per, 2 * (int'(div) + 1));
  endtask

  task automatic t_reset();
    chk(!bclk_o && !ws_o && !sd_o, "R1", "lines low after reset", {bclk_o, ws_o, sd_o}, 0);
    chk(fifo_level == 0 && !underrun && !req_o && !fifo_full, "R8", "fifo idle after reset",
        {fifo_level, underrun, req_o}, 0);
  endtask

  task automatic t_underrun_flush();
    run_int("R9", 3'd1, 1'b0, 1'b0, 4'd1, 2, 3);
    chk(underrun == 1'b1, "R9", "underrun flag set", underrun, 1);
    repeat (5) @(negedge clk);
    chk(underrun == 1'b1, "R9", "underrun flag held", underrun, 1);
    push_n(4);
    chk(fifo_level == 6'd4, "R10", "level before flush", fifo_level, 4);
    @(negedge clk);
    flush = 1; wr_en = 1; wr_data = 24'h123456;
    @(negedge clk);
    flush = 0; wr_en = 0;
    chk(fifo_level == 0, "R10", "level after flush", fifo_level, 0);
    chk(underrun == 0, "R10", "underrun cleared by flush", underrun, 0);
  endtask

  task automatic t_request();
    idle_flush();
    cfg_div = 4'd15; cfg_req_thr = 6'd8; cfg_bclk_master = 1; cfg_fclk_master = 1;
    push_n(8);
    chk(req_o == 0, "R8", "no request while disabled", req_o, 0);
    @(negedge clk);
    enable = 1; play_en = 1;
    @(negedge clk);
    chk(req_o == 1, "R8", "request at level equal threshold", req_o, 1);
    push(24'h0F0F0F);
    chk(req_o == 0, "R8", "no request above threshold", req_o, 0);
    @(negedge clk);
    play_en = 0;
    @(negedge clk);
    chk(req_o == 0, "R8", "no request with playback off", req_o, 0);
    idle_flush();
  endtask

  task automatic t_play_off();
    bit any_sd = 0;
    idle_flush();
    cfg_width = 3'd4; cfg_msb_just = 1; cfg_mono = 0; cfg_div = 4'd1;
    push_n(2);
    @(negedge clk);
    enable = 1; play_en = 0;
    cap_int(64);
    for (int k = 0; k < 64; k++) if (sdb[k]) any_sd = 1;
    enable = 0;
    chk(any_sd == 0, "R11", "data silent with playback off", any_sd, 0);
    chk(fifo_level == 6'd2, "R11", "no words consumed", fifo_level, 2);
  endtask

  task automatic t_disable();
    bit bad = 0;
    idle_flush();
    cfg_div = 4'd0; cfg_width = 3'd4; cfg_msb_just = 1;
    push_n(8);
    @(negedge clk);
    enable = 1; play_en = 1;
    repeat (100) @(negedge clk);
    enable = 0;
    @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      if (bclk_o || ws_o || sd_o) bad = 1;
      @(negedge clk);
    end
    chk(bad == 0, "R1", "lines held low when disabled", bad, 0);
    run_int("R1", 3'd4, 1'b1, 1'b0, 4'd0, 1, 2);
  endtask

  task automatic t_ext(input logic fmaster);
    bit bad = 0;
    idle_flush();
    cfg_width = 3'd1; cfg_msb_just = 0; cfg_mono = 0;
    cfg_bclk_master = 0; cfg_fclk_master = fmaster;
    push_n(2);
    @(negedge clk);
    ext_bclk = 1; ext_ws = 0;
    repeat (4) @(negedge clk);
    enable = 1; play_en = 1;
    repeat (2) @(negedge clk);
    for (int k = 0; k < 64; k++) begin
      ext_bclk = 0;
      ext_ws = fmaster ? 1'b0 : (k >= 32);
      repeat (H) @(negedge clk);
      if (bclk_o) bad = 1;
      if (!fmaster && ws_o) bad = 1;
      sdb[k] = sd_o;
      wsb[k] = ws_o;
      ext_bclk = 1;
      repeat (H) @(negedge clk);
    end
    enable = 0; play_en = 0;
    chk(bad == 0, "R7", "slave role lines stay low", bad, 0);
    check_frames(1, 3'd1, 1'b0, 1'b0, fmaster, "R7");
    cfg_bclk_master = 1; cfg_fclk_master = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    run_int("R4 R5 R6", 3'd1, 1'b0, 1'b0, 4'd1, 3, 6);   // 16-bit, standard
    run_int("R4 R5",    3'd4, 1'b1, 1'b0, 4'd2, 2, 4);   // 24-bit, justified
    run_int("R4",       3'd0, 1'b0, 1'b0, 4'd0, 2, 4);   // 8-bit
    run_int("R4 R5",    3'd3, 1'b1, 1'b0, 4'd1, 2, 4);   // 20-bit
    run_int("R4",       3'd2, 1'b1, 1'b0, 4'd1, 1, 2);   // unsupported code
    run_int("R6",       3'd1, 1'b1, 1'b1, 4'd1, 3, 3);   // mono
    t_underrun_flush();
    t_request();
    t_play_off();
    t_disable();
    t_ext(1'b0);
    t_ext(1'b1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule